// File: doc/BRIEF.md
# Load Data Aligner and Merger

This block is the writeback-side stage of a load pipeline on a big-endian machine. It receives the aligned 32-bit memory word fetched for a load, the two low address bits of the load, a code for the kind of load, and the present contents of the destination register. From these it forms the 32-bit value to write back and presents it one clock later. The cases it handles are signed and unsigned byte and halfword loads, the plain word load, and the upper-immediate form. It also handles the two partial-word merges, left and right, that together build a word read from an unaligned address.

Byte lanes are numbered big-endian: byte offset 0 is bits 31:24 of the memory word and offset 3 is bits 7:0. A left merge copies the bytes from the addressed byte through the end of the word into the most significant positions of the destination. A right merge copies the bytes from the start of the word through the addressed byte into the least significant positions. In both merges the destination bytes that are not written keep their old value. A left merge at the first byte of an unaligned word, followed by a right merge at its last byte, leaves the whole word in the register.

The block has no sequencing of its own. Its only state is the output register, which has two conditions: idle and holding the last result. Each cycle it either loads a new result (when `ld_valid` is high) or holds the previous one.

Top module: `load_aligner`

## Requirements
- R1: While `rst_n` is low, and after it is released with no load issued, `wb_valid` is 0 and `wb_data` is 0.
- R2: Kind code 0 (signed byte) returns the byte at offset `addr_lo`, where offset 0 is bits 31:24 and offset 3 is bits 7:0, with its bit 7 copied into bits 31:8.
- R3: Kind code 1 (unsigned byte) returns the same byte as R2 with bits 31:8 cleared.
- R4: Kind codes 2 (signed halfword) and 3 (unsigned halfword) take bits 31:16 when `addr_lo[1]` is 0 and bits 15:0 when it is 1, then sign-extend or zero-extend them. `addr_lo[0]` has no effect on the result.
- R5: Kind code 4 (word) returns the memory word unchanged for every value of `addr_lo`.
- R6: Kind code 5 (left merge) at offset k places memory bytes k through 3 into destination byte positions 0 through 3−k, counted from the most significant end. All other destination bytes keep the value of `dest_old`. At offset 0 the result is the full memory word.
- R7: Kind code 6 (right merge) at offset k places memory bytes 0 through k into the lowest k+1 destination byte positions, with byte k least significant. All other destination bytes keep the value of `dest_old`. At offset 3 the result is the full memory word.
- R8: A left merge at offset 1 of the word holding addresses 0–3, followed by a right merge at offset 0 of the next word (with `dest_old` of the second load set to the result of the first), yields the unaligned word made of bytes 1, 2, 3 and 4.
- R9: Kind code 7 (upper immediate) places `mem_word[15:0]` into bits 31:16 and clears bits 15:0.
- R10: `wb_valid` equals `ld_valid` delayed by one clock. The result of a load appears on `wb_data` one clock after `ld_valid` is sampled high. While `ld_valid` is low, `wb_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load result is to be formed this cycle |
| ld_kind | input | 3 | Load kind code (see R2–R9) |
| addr_lo | input | 2 | Two low bits of the load address (byte offset) |
| mem_word | input | 32 | Aligned memory word fetched for the load |
| dest_old | input | 32 | Current destination register contents |
| wb_valid | output | 1 | Registered copy of `ld_valid` |
| wb_data | output | 32 | Registered writeback value |

## Verification
The main checks use one memory word with distinct bytes and a set top bit in both the first and last lanes. With that word, each offset exposes a wrong lane choice, and each signed kind shows whether the extension came from the correct bit. The merges are driven with a `dest_old` whose bytes all differ from the memory bytes, so a lane that was overwritten when it should have been kept, or the reverse, shows up directly. The two offsets at the ends are tried for each merge to catch off-by-one boundaries. A chained left-then-right pair checks that the two merges compose into the unaligned word. A long run of random kinds, offsets, words, register contents and idle gaps is also compared every clock against a byte-array model, which covers the hold behaviour and the one-cycle latency.

// File: rtl/load_align_pkg.sv
package load_align_pkg;

    localparam int DATA_W = 32;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        LK_BYTE_S = 3'd0,
        LK_BYTE_U = 3'd1,
        LK_HALF_S = 3'd2,
        LK_HALF_U = 3'd3,
        LK_WORD   = 3'd4,
        LK_LEFT   = 3'd5,
        LK_RIGHT  = 3'd6,
        LK_UPPER  = 3'd7
    } load_kind_e;

endpackage

// File: rtl/ld_lane_extract.sv
module ld_lane_extract
    import load_align_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int BYTES  = WORD_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int HALF_W = WORD_W / 2
) (
    input  load_kind_e        kind,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] ext_val
);

    logic [7:0]        lane [BYTES];
    logic [7:0]        sel_byte;
    logic [HALF_W-1:0] sel_half;

    // big-endian lanes: lane 0 is the most significant byte
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane[g] = word[WORD_W-1-8*g -: 8];
    end

    assign sel_byte = lane[off];
    // the most significant offset bit picks the halfword, bit 0 is ignored
    assign sel_half = off[OFF_W-1] ? word[HALF_W-1:0] : word[WORD_W-1 -: HALF_W];

    always_comb begin
        unique case (kind)
            LK_BYTE_S: ext_val = {{(WORD_W-8){sel_byte[7]}}, sel_byte};
            LK_BYTE_U: ext_val = {{(WORD_W-8){1'b0}}, sel_byte};
            LK_HALF_S: ext_val = {{(WORD_W-HALF_W){sel_half[HALF_W-1]}}, sel_half};
            LK_HALF_U: ext_val = {{(WORD_W-HALF_W){1'b0}}, sel_half};
            LK_UPPER:  ext_val = {word[HALF_W-1:0], {HALF_W{1'b0}}};
            LK_WORD, LK_LEFT, LK_RIGHT: ext_val = word;
        endcase
    end

endmodule

// File: rtl/ld_word_merge.sv
module ld_word_merge #(
    parameter int WORD_W = 32,
    localparam int BYTES = WORD_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int IDX_W = OFF_W + 1
) (
    input  logic              left_sel,
    input  logic [OFF_W-1:0]  off,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] old,
    output logic [WORD_W-1:0] merged
);

    logic [7:0] mem_lane [BYTES];
    logic [7:0] old_lane [BYTES];
    logic [IDX_W-1:0] right_thr;

    // first destination position a right merge writes
    assign right_thr = IDX_W'(BYTES - 1) - {1'b0, off};

    for (genvar p = 0; p < BYTES; p++) begin : g_pos
        logic [IDX_W-1:0] l_src;
        logic [IDX_W-1:0] r_src;
        logic [7:0]       pos_val;

        assign mem_lane[p] = word[WORD_W-1-8*p -: 8];
        assign old_lane[p] = old[WORD_W-1-8*p -: 8];

        assign l_src = IDX_W'(p) + {1'b0, off};
        assign r_src = IDX_W'(p) - right_thr;

        always_comb begin
            if (left_sel) begin
                if (l_src < IDX_W'(BYTES)) pos_val = mem_lane[l_src[OFF_W-1:0]];
                else                       pos_val = old_lane[p];
            end else begin
                if (IDX_W'(p) >= right_thr) pos_val = mem_lane[r_src[OFF_W-1:0]];
                else                        pos_val = old_lane[p];
            end
        end

        assign merged[WORD_W-1-8*p -: 8] = pos_val;
    end

endmodule

// File: rtl/load_aligner.sv
module load_aligner
    import load_align_pkg::*;
#(
    parameter int WORD_W = DATA_W,
    localparam int BYTES = WORD_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [2:0]        ld_kind,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] dest_old,
    output logic              wb_valid,
    output logic [WORD_W-1:0] wb_data
);

    load_kind_e        kind;
    logic [WORD_W-1:0] ext_val;
    logic [WORD_W-1:0] merge_val;
    logic [WORD_W-1:0] next_val;

    assign kind = load_kind_e'(ld_kind);

    ld_lane_extract #(.WORD_W(WORD_W)) u_extract (
        .kind    (kind),
        .off     (addr_lo),
        .word    (mem_word),
        .ext_val (ext_val)
    );

    ld_word_merge #(.WORD_W(WORD_W)) u_merge (
        .left_sel (kind == LK_LEFT),
        .off      (addr_lo),
        .word     (mem_word),
        .old      (dest_old),
        .merged   (merge_val)
    );

    always_comb begin
        unique case (kind)
            LK_LEFT, LK_RIGHT: next_val = merge_val;
            LK_BYTE_S, LK_BYTE_U, LK_HALF_S, LK_HALF_U,
            LK_WORD, LK_UPPER:  next_val = ext_val;
        endcase
    end

    // output register: idle after reset, holds the last result otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= ld_valid;
            if (ld_valid) wb_data <= next_val;
        end
    end

    assert_valid_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> wb_valid);
    assert_idle_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !wb_valid);
    assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> $stable(wb_data));
    assert_sbyte_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && kind == LK_BYTE_S) |=> (wb_data[WORD_W-1:8] == {(WORD_W-8){wb_data[7]}}));
    assert_ubyte_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && kind == LK_BYTE_U) |=> (wb_data[WORD_W-1:8] == '0));
    assert_upper_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && kind == LK_UPPER) |=> (wb_data[WORD_W/2-1:0] == '0));
    assert_word_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && kind == LK_WORD) |=> (wb_data == $past(mem_word)));
    assert_left_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && kind == LK_LEFT && addr_lo == OFF_W'(BYTES-1))
        |=> (wb_data[WORD_W-9:0] == $past(dest_old[WORD_W-9:0])));
    assert_right_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && kind == LK_RIGHT && addr_lo == '0)
        |=> (wb_data[WORD_W-1:8] == $past(dest_old[WORD_W-1:8])));

endmodule

// File: tb/tb_load_aligner.sv
module tb_load_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_kind = 3'd0;
    logic [1:0]  addr_lo = 2'd0;
    logic [31:0] mem_word = 32'h0;
    logic [31:0] dest_old = 32'h0;
    logic        wb_valid;
    logic [31:0] wb_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic        exp_valid = 1'b0;
    logic [31:0] exp_data = 32'h0;
    string       exp_tag = "R1";

    always #5 clk = ~clk;

    load_aligner dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_kind(ld_kind),
        .addr_lo(addr_lo), .mem_word(mem_word), .dest_old(dest_old),
        .wb_valid(wb_valid), .wb_data(wb_data)
    );

    // behavioural model: byte arrays, index 0 = most significant byte
    function automatic logic [31:0] model(input logic [2:0] k, input int off,
                                          input logic [31:0] m, input logic [31:0] o);
        byte unsigned mb[4];
        byte unsigned db[4];
        int sh;
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            mb[i] = m[31-8*i -: 8];
            db[i] = o[31-8*i -: 8];
        end
        case (k)
            3'd0: r = 32'(signed'(8'(mb[off])));
            3'd1: r = {24'h0, mb[off]};
            3'd2: begin sh = (off / 2) * 2; r = 32'(signed'({mb[sh], mb[sh+1]})); end
            3'd3: begin sh = (off / 2) * 2; r = {16'h0, mb[sh], mb[sh+1]}; end
            3'd4: r = m;
            3'd5: begin
                for (int i = 0; i + off < 4; i++) db[i] = mb[i+off];
                r = {db[0], db[1], db[2], db[3]};
            end
            3'd6: begin
                for (int i = 0; i <= off; i++) db[3-off+i] = mb[i];
                r = {db[0], db[1], db[2], db[3]};
            end
            default: r = {m[15:0], 16'h0};
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_data  <= 32'h0;
            exp_tag   <= "R1";
        end else begin
            exp_valid <= ld_valid;
            if (ld_valid) begin
                exp_data <= model(ld_kind, int'(addr_lo), mem_word, dest_old);
                exp_tag  <= tag_of(ld_kind);
            end else begin
                exp_tag <= "R10";
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            tests++;
            if (wb_valid !== exp_valid || wb_data !== exp_data) begin
                fails++;
                $display("FAIL %s (model): got valid=%0b data=%h expected valid=%0b data=%h",
                         exp_tag, wb_valid, wb_data, exp_valid, exp_data);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: got cycles=%0d expected completion", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load(input logic [2:0] k, input logic [1:0] a, input logic [31:0] m,
                        input logic [31:0] o, input logic [31:0] exp, input string req);
        @(negedge clk);
        ld_valid = 1'b1; ld_kind = k; addr_lo = a; mem_word = m; dest_old = o;
        @(negedge clk);
        check(req, wb_data, exp);
        check(req, {31'h0, wb_valid}, 32'h1);
        ld_valid = 1'b0;
    endtask

    localparam logic [31:0] MW = 32'h8A4B_C3D4;
    localparam logic [31:0] OD = 32'h1122_3344;

    initial begin
        logic [31:0] first;
        repeat (3) @(negedge clk);
        check("R1", wb_data, 32'h0);
        check("R1", {31'h0, wb_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", wb_data, 32'h0);

        load(3'd0, 2'd0, MW, OD, 32'hFFFF_FF8A, "R2");
        load(3'd0, 2'd3, MW, OD, 32'hFFFF_FFD4, "R2");
        load(3'd0, 2'd1, MW, OD, 32'h0000_004B, "R2");
        load(3'd1, 2'd0, MW, OD, 32'h0000_008A, "R3");
        load(3'd1, 2'd2, MW, OD, 32'h0000_00C3, "R3");
        load(3'd2, 2'd0, MW, OD, 32'hFFFF_8A4B, "R4");
        load(3'd2, 2'd1, MW, OD, 32'hFFFF_8A4B, "R4");
        load(3'd3, 2'd2, MW, OD, 32'h0000_C3D4, "R4");
        load(3'd3, 2'd3, MW, OD, 32'h0000_C3D4, "R4");
        load(3'd4, 2'd2, MW, OD, MW, "R5");
        load(3'd5, 2'd1, MW, OD, 32'h4BC3_D444, "R6");
        load(3'd5, 2'd2, MW, OD, 32'hC3D4_3344, "R6");
        load(3'd5, 2'd0, MW, OD, MW, "R6");
        load(3'd6, 2'd0, MW, OD, 32'h1122_338A, "R7");
        load(3'd6, 2'd2, MW, OD, 32'h118A_4BC3, "R7");
        load(3'd6, 2'd3, MW, OD, MW, "R7");
        load(3'd7, 2'd1, MW, OD, 32'hC3D4_0000, "R9");

        // unaligned word at addresses 1..4
        load(3'd5, 2'd1, 32'hAABB_CCDD, 32'h0, 32'hBBCC_DD00, "R8");
        first = wb_data;
        load(3'd6, 2'd0, 32'hEEFF_0011, first, 32'hBBCC_DDEE, "R8");

        // idle cycle with changed inputs: output must hold
        @(negedge clk);
        ld_kind = 3'd4; mem_word = 32'h1234_5678; addr_lo = 2'd0;
        @(negedge clk);
        check("R10", wb_data, 32'hBBCC_DDEE);
        check("R10", {31'h0, wb_valid}, 32'h0);

        // random traffic, compared each clock by the model
        for (int n = 0; n < 2000; n++) begin
            ld_valid = ($urandom_range(0, 4) != 0);
            ld_kind  = 3'($urandom_range(0, 7));
            addr_lo  = 2'($urandom_range(0, 3));
            mem_word = $urandom;
            dest_old = $urandom;
            @(negedge clk);
        end
        ld_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule